// File: doc/BRIEF.md
# ASID-Tagged Data Translation Buffer

This block turns 32-bit virtual data addresses into physical addresses. It holds a small set of 4 KiB page entries and a separate way of eight entries. Each of those eight entries covers one 512 MiB region. Every entry carries an 8-bit address-space tag, a 4-bit attribute field, and write and execute permission bits.

The privilege ring of the access selects its tags through a 32-bit ring-to-tag register. The ring 0 tag is fixed at 1. A tag of 0 marks a dead entry. Out of reset, the large-region way gives ring 0 a full identity map that is writable, executable and uncached, so code can run before any page tables exist.

A lookup is purely combinational and reports exactly one of four outcomes: hit, miss, multiple match, or permission fault. Software writes or kills single entries through a direct write port and an invalidate port. A refill engine pushes page table entries into the page way, and a round-robin victim pointer picks the slot.

Top module: `asid_tlb`

## Requirements
- R1: After reset, large-region entry k (k = 0..7) matches VA[31:29] == k, maps to PA[31:29] == k, has tag 1, is writable and executable, and carries attribute 4'h2. All page entries reset to tag 0.
- R2: A large-region entry that is tagged 1 can be used only by ring 0. A lookup of such an entry from ring 1, 2 or 3 gives a permission fault.
- R3: When exactly one live entry matches and the access is permitted, lk_hit_o is 1 and lk_attr_o is the entry attribute. lk_pa_o is {ppn, VA[11:0]} for a page entry and {region, VA[28:0]} for a large-region entry.
- R4: When more than one live entry matches, only lk_multi_o is raised, and lk_pa_o and lk_attr_o are 0.
- R5: When no live entry matches, only lk_miss_o is raised, and lk_pa_o and lk_attr_o are 0.
- R6: An entry with tag 0 never matches. The invalidate port writes tag 0 into the chosen entry of either way.
- R7: Byte n of the ring-to-tag register holds the tag for ring n. The reset value is 32'h04030201. Writes to byte 0 are ignored, so byte 0 always reads as 1.
- R8: A fill decodes the entry as ppn = [31:12], execute = [7], write = [6], ring = [5:4] and attribute = [3:0]. Its tag is the current register byte for that ring. The fill goes to the slot named by a victim pointer. The pointer starts at 0, steps by one on each fill, and wraps to 0 after N_PAGE-1. Writes and invalidates do not move the pointer.
- R9: A single match still gives a permission fault in three cases: the access is a write and the entry is not writable; the access is an execute and the entry is not executable; or the access ring is greater than the entry ring.
- R10: A lookup result follows its inputs within the same cycle. Writes, invalidates, fills and register writes take effect at the next rising edge. While lk_valid_i is 0 all four outcome flags are 0. When several ports target the same slot in one cycle, a write beats an invalidate, and an invalidate beats a fill.
- R11: An entry matches only if its tag equals some byte of the ring-to-tag register. Its ring is the lowest ring whose byte equals its tag. Rewriting a byte therefore switches which address space is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_ring_i | input | 2 | Ring of the access |
| lk_wr_i | input | 1 | Access is a write |
| lk_ex_i | input | 1 | Access is an instruction fetch |
| lk_hit_o | output | 1 | Single permitted match |
| lk_miss_o | output | 1 | No match |
| lk_multi_o | output | 1 | More than one match |
| lk_perm_o | output | 1 | Single match, access not allowed |
| lk_pa_o | output | 32 | Physical address, 0 unless hit |
| lk_attr_o | output | 4 | Entry attribute, 0 unless hit |
| wr_en_i | input | 1 | Direct entry write |
| wr_boot_i | input | 1 | Write targets the large-region way |
| wr_idx_i | input | 3 | Slot written |
| wr_vpn_i | input | 20 | Virtual page; upper 3 bits used for large regions |
| wr_ppn_i | input | 20 | Physical page; upper 3 bits used for large regions |
| wr_asid_i | input | 8 | Entry tag |
| wr_attr_i | input | 4 | Entry attribute |
| wr_w_i | input | 1 | Entry writable |
| wr_x_i | input | 1 | Entry executable |
| inv_en_i | input | 1 | Invalidate one entry |
| inv_boot_i | input | 1 | Invalidate targets the large-region way |
| inv_idx_i | input | 3 | Slot invalidated |
| fill_en_i | input | 1 | Refill strobe |
| fill_vpn_i | input | 20 | Virtual page of the refill |
| fill_pte_i | input | 32 | Refilled page table entry |
| rasid_we_i | input | 1 | Ring-to-tag register write |
| rasid_i | input | 32 | Ring-to-tag write data |

## Verification
The checker's round-robin rule assumes that every fill strobe is a real refill, with no separate hold. The bench therefore raises at most one of the write, invalidate and fill ports in any cycle. Slot indices are assumed to be below the way depth, and the bench draws them only from 0 to 7. Lookups are driven half a cycle away from the edges, so the outcome checks see stable inputs. Random tags, pages and register bytes are drawn from small pools, so that hits, misses, multiple matches and permission faults all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_OFF   = 12;
  localparam int VPN_W    = VA_W - PG_OFF;
  localparam int BOOT_W   = 3;
  localparam int N_BOOT   = 1 << BOOT_W;
  localparam int ASID_W   = 8;
  localparam int ATTR_W   = 4;
  localparam int RING_W   = 2;
  localparam int N_RING   = 1 << RING_W;
  localparam int RASID_W  = N_RING * ASID_W;
  localparam logic [ASID_W-1:0]  KERN_ASID = 8'd1;
  localparam logic [ATTR_W-1:0]  BOOT_ATTR = 4'h2;
  localparam logic [RASID_W-1:0] RASID_RST = 32'h0403_0201;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
    logic              wr;
    logic              ex;
  } pg_ent_t;

  typedef struct packed {
    logic [BOOT_W-1:0] vpn;
    logic [BOOT_W-1:0] ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
    logic              wr;
    logic              ex;
  } bt_ent_t;

  // {found, ring}; lowest ring wins when tags repeat
  function automatic logic [RING_W:0] asid_ring(input logic [ASID_W-1:0] asid,
                                                input logic [RASID_W-1:0] rasid);
    logic [RING_W:0] r;
    r = '0;
    for (int i = N_RING - 1; i >= 0; i--)
      if (asid != '0 && rasid[i*ASID_W +: ASID_W] == asid) r = {1'b1, RING_W'(i)};
    return r;
  endfunction
endpackage

// File: rtl/tlb_rasid.sv
module tlb_rasid
  import tlb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [RASID_W-1:0] wdata_i,
  output logic [RASID_W-1:0] rasid_o
);
  logic [RASID_W-ASID_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   hi_q <= RASID_RST[RASID_W-1:ASID_W];
    else if (we_i) hi_q <= wdata_i[RASID_W-1:ASID_W];

  assign rasid_o = {hi_q, KERN_ASID};
endmodule

// File: rtl/tlb_page_way.sv
module tlb_page_way
  import tlb_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  pg_ent_t            wr_ent_i,
  input  logic               inv_en_i,
  input  logic [IW-1:0]      inv_idx_i,
  input  logic               fill_en_i,
  input  pg_ent_t            fill_ent_i,
  input  logic [RASID_W-1:0] rasid_i,
  input  logic [VPN_W-1:0]   vpn_i,
  output logic [N-1:0]       match_o,
  output pg_ent_t            sel_o,
  output logic [RING_W-1:0]  sel_ring_o,
  output logic [IW-1:0]      victim_o
);
  pg_ent_t           msk_v  [N];
  logic [RING_W-1:0] ring_v [N];
  logic [IW-1:0]     vic_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    pg_ent_t         q;
    logic [RING_W:0] ri;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                q <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))     q <= wr_ent_i;
      else if (inv_en_i && inv_idx_i == IW'(g))   q.asid <= '0;
      else if (fill_en_i && vic_q == IW'(g))      q <= fill_ent_i;
    assign ri         = asid_ring(q.asid, rasid_i);
    assign match_o[g] = ri[RING_W] && (q.vpn == vpn_i);
    assign msk_v[g]   = match_o[g] ? q : '0;
    assign ring_v[g]  = match_o[g] ? ri[RING_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        vic_q <= '0;
    else if (fill_en_i) vic_q <= (vic_q == IW'(N-1)) ? '0 : vic_q + 1'b1;

  always_comb begin
    sel_o      = '0;
    sel_ring_o = '0;
    for (int i = 0; i < N; i++) begin
      sel_o      = sel_o | msk_v[i];
      sel_ring_o = sel_ring_o | ring_v[i];
    end
  end

  assign victim_o = vic_q;
endmodule

// File: rtl/tlb_boot_way.sv
module tlb_boot_way
  import tlb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BOOT_W-1:0]  wr_idx_i,
  input  bt_ent_t            wr_ent_i,
  input  logic               inv_en_i,
  input  logic [BOOT_W-1:0]  inv_idx_i,
  input  logic [RASID_W-1:0] rasid_i,
  input  logic [BOOT_W-1:0]  region_i,
  output logic [N_BOOT-1:0]  match_o,
  output bt_ent_t            sel_o,
  output logic [RING_W-1:0]  sel_ring_o
);
  bt_ent_t           msk_v  [N_BOOT];
  logic [RING_W-1:0] ring_v [N_BOOT];

  for (genvar g = 0; g < N_BOOT; g++) begin : g_ent
    bt_ent_t         q;
    logic [RING_W:0] ri;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        q.vpn  <= BOOT_W'(g);
        q.ppn  <= BOOT_W'(g);
        q.asid <= KERN_ASID;
        q.attr <= BOOT_ATTR;
        q.wr   <= 1'b1;
        q.ex   <= 1'b1;
      end
      else if (wr_en_i && wr_idx_i == BOOT_W'(g))   q <= wr_ent_i;
      else if (inv_en_i && inv_idx_i == BOOT_W'(g)) q.asid <= '0;
    assign ri         = asid_ring(q.asid, rasid_i);
    assign match_o[g] = ri[RING_W] && (q.vpn == region_i);
    assign msk_v[g]   = match_o[g] ? q : '0;
    assign ring_v[g]  = match_o[g] ? ri[RING_W-1:0] : '0;
  end

  always_comb begin
    sel_o      = '0;
    sel_ring_o = '0;
    for (int i = 0; i < N_BOOT; i++) begin
      sel_o      = sel_o | msk_v[i];
      sel_ring_o = sel_ring_o | ring_v[i];
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int N_PAGE = 8,
  parameter int PIDX_W = $clog2(N_PAGE),
  parameter int IDX_W  = (PIDX_W > BOOT_W) ? PIDX_W : BOOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lk_valid_i,
  input  logic [VA_W-1:0]    lk_va_i,
  input  logic [RING_W-1:0]  lk_ring_i,
  input  logic               lk_wr_i,
  input  logic               lk_ex_i,
  output logic               lk_hit_o,
  output logic               lk_miss_o,
  output logic               lk_multi_o,
  output logic               lk_perm_o,
  output logic [VA_W-1:0]    lk_pa_o,
  output logic [ATTR_W-1:0]  lk_attr_o,
  input  logic               wr_en_i,
  input  logic               wr_boot_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [VPN_W-1:0]   wr_ppn_i,
  input  logic [ASID_W-1:0]  wr_asid_i,
  input  logic [ATTR_W-1:0]  wr_attr_i,
  input  logic               wr_w_i,
  input  logic               wr_x_i,
  input  logic               inv_en_i,
  input  logic               inv_boot_i,
  input  logic [IDX_W-1:0]   inv_idx_i,
  input  logic               fill_en_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [VA_W-1:0]    fill_pte_i,
  input  logic               rasid_we_i,
  input  logic [RASID_W-1:0] rasid_i
);
  localparam int CNT_W = $clog2(N_PAGE + N_BOOT + 1);

  logic [RASID_W-1:0] rasid;
  pg_ent_t            pg_wr, pg_fill, pg_sel;
  bt_ent_t            bt_wr, bt_sel;
  logic [N_PAGE-1:0]  pg_match;
  logic [N_BOOT-1:0]  bt_match;
  logic [RING_W-1:0]  pg_ring, bt_ring, ent_ring;
  logic [PIDX_W-1:0]  pg_victim;
  logic [CNT_W-1:0]   n_match;
  logic               pg_any, ent_wr, ent_ex, bad, single;
  logic [RING_W-1:0]  fill_ring;

  tlb_rasid u_rasid (
    .clk_i, .rst_ni, .we_i(rasid_we_i), .wdata_i(rasid_i), .rasid_o(rasid)
  );

  assign pg_wr = '{vpn: wr_vpn_i, ppn: wr_ppn_i, asid: wr_asid_i,
                   attr: wr_attr_i, wr: wr_w_i, ex: wr_x_i};
  assign bt_wr = '{vpn: wr_vpn_i[VPN_W-1 -: BOOT_W], ppn: wr_ppn_i[VPN_W-1 -: BOOT_W],
                   asid: wr_asid_i, attr: wr_attr_i, wr: wr_w_i, ex: wr_x_i};

  // refill entry layout: ppn | .. | x | w | ring | attr
  assign fill_ring = fill_pte_i[ATTR_W +: RING_W];
  assign pg_fill   = '{vpn:  fill_vpn_i,
                       ppn:  fill_pte_i[VA_W-1:PG_OFF],
                       asid: rasid[fill_ring*ASID_W +: ASID_W],
                       attr: fill_pte_i[ATTR_W-1:0],
                       wr:   fill_pte_i[ATTR_W+RING_W],
                       ex:   fill_pte_i[ATTR_W+RING_W+1]};

  tlb_page_way #(.N(N_PAGE), .IW(PIDX_W)) u_page (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en_i && !wr_boot_i),
    .wr_idx_i  (wr_idx_i[PIDX_W-1:0]),
    .wr_ent_i  (pg_wr),
    .inv_en_i  (inv_en_i && !inv_boot_i),
    .inv_idx_i (inv_idx_i[PIDX_W-1:0]),
    .fill_en_i,
    .fill_ent_i(pg_fill),
    .rasid_i   (rasid),
    .vpn_i     (lk_va_i[VA_W-1:PG_OFF]),
    .match_o   (pg_match),
    .sel_o     (pg_sel),
    .sel_ring_o(pg_ring),
    .victim_o  (pg_victim)
  );

  tlb_boot_way u_boot (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en_i && wr_boot_i),
    .wr_idx_i  (wr_idx_i[BOOT_W-1:0]),
    .wr_ent_i  (bt_wr),
    .inv_en_i  (inv_en_i && inv_boot_i),
    .inv_idx_i (inv_idx_i[BOOT_W-1:0]),
    .rasid_i   (rasid),
    .region_i  (lk_va_i[VA_W-1 -: BOOT_W]),
    .match_o   (bt_match),
    .sel_o     (bt_sel),
    .sel_ring_o(bt_ring)
  );

  assign n_match  = CNT_W'($countones({pg_match, bt_match}));
  assign pg_any   = |pg_match;
  assign ent_ring = pg_any ? pg_ring   : bt_ring;
  assign ent_wr   = pg_any ? pg_sel.wr : bt_sel.wr;
  assign ent_ex   = pg_any ? pg_sel.ex : bt_sel.ex;
  assign bad      = (lk_ring_i > ent_ring) || (lk_wr_i && !ent_wr) || (lk_ex_i && !ent_ex);
  assign single   = lk_valid_i && (n_match == CNT_W'(1));

  assign lk_miss_o  = lk_valid_i && (n_match == '0);
  assign lk_multi_o = lk_valid_i && (n_match > CNT_W'(1));
  assign lk_perm_o  = single && bad;
  assign lk_hit_o   = single && !bad;

  always_comb begin
    lk_pa_o   = '0;
    lk_attr_o = '0;
    if (lk_hit_o) begin
      lk_pa_o   = pg_any ? {pg_sel.ppn, lk_va_i[PG_OFF-1:0]}
                         : {bt_sel.ppn, lk_va_i[VA_W-BOOT_W-1:0]};
      lk_attr_o = pg_any ? pg_sel.attr : bt_sel.attr;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int N_PAGE = 8,
  parameter int PIDX_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [31:0]       lk_va_i,
  input logic              lk_hit_o,
  input logic              lk_miss_o,
  input logic              lk_multi_o,
  input logic              lk_perm_o,
  input logic [31:0]       lk_pa_o,
  input logic [3:0]        lk_attr_o,
  input logic              fill_en_i,
  input logic [PIDX_W-1:0] victim
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $countones({lk_hit_o, lk_miss_o, lk_multi_o, lk_perm_o}) == 1); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_multi_o || lk_perm_o)); // R10

  AST_PA_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[11:0] == lk_va_i[11:0]); // R3

  AST_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_pa_o == '0 && lk_attr_o == '0)); // R5

  AST_RR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> victim == (($past(victim) == PIDX_W'(N_PAGE-1)) ? '0 : $past(victim) + 1'b1)); // R8

  AST_RR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en_i |=> $stable(victim)); // R8
endmodule

bind asid_tlb tlb_chk #(.N_PAGE(N_PAGE), .PIDX_W(PIDX_W)) u_chk (
  .clk_i, .rst_ni, .lk_valid_i, .lk_va_i, .lk_hit_o, .lk_miss_o, .lk_multi_o,
  .lk_perm_o, .lk_pa_o, .lk_attr_o, .fill_en_i, .victim(pg_victim)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_ni = 0;
  logic lk_valid_i = 0, lk_wr_i = 0, lk_ex_i = 0;
  logic [31:0] lk_va_i = 0;
  logic [1:0]  lk_ring_i = 0;
  logic lk_hit_o, lk_miss_o, lk_multi_o, lk_perm_o;
  logic [31:0] lk_pa_o;
  logic [3:0]  lk_attr_o;
  logic wr_en_i = 0, wr_boot_i = 0, wr_w_i = 0, wr_x_i = 0;
  logic [2:0]  wr_idx_i = 0;
  logic [19:0] wr_vpn_i = 0, wr_ppn_i = 0;
  logic [7:0]  wr_asid_i = 0;
  logic [3:0]  wr_attr_i = 0;
  logic inv_en_i = 0, inv_boot_i = 0;
  logic [2:0]  inv_idx_i = 0;
  logic fill_en_i = 0;
  logic [19:0] fill_vpn_i = 0;
  logic [31:0] fill_pte_i = 0;
  logic rasid_we_i = 0;
  logic [31:0] rasid_i = 0;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  asid_tlb uut (
    .clk_i(clk), .rst_ni, .lk_valid_i, .lk_va_i, .lk_ring_i, .lk_wr_i, .lk_ex_i,
    .lk_hit_o, .lk_miss_o, .lk_multi_o, .lk_perm_o, .lk_pa_o, .lk_attr_o,
    .wr_en_i, .wr_boot_i, .wr_idx_i, .wr_vpn_i, .wr_ppn_i, .wr_asid_i, .wr_attr_i,
    .wr_w_i, .wr_x_i, .inv_en_i, .inv_boot_i, .inv_idx_i,
    .fill_en_i, .fill_vpn_i, .fill_pte_i, .rasid_we_i, .rasid_i
  );

  // reference state
  logic [19:0] m_pvpn [8], m_pppn [8];
  logic [7:0]  m_pasid [8];
  logic [3:0]  m_pattr [8];
  logic        m_pw [8], m_px [8];
  logic [2:0]  m_bvpn [8], m_bppn [8];
  logic [7:0]  m_basid [8];
  logic [3:0]  m_battr [8];
  logic        m_bw [8], m_bx [8];
  logic [31:0] m_rasid;
  int          m_vic;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_pvpn[i] = 0; m_pppn[i] = 0; m_pasid[i] = 0; m_pattr[i] = 0; m_pw[i] = 0; m_px[i] = 0;
      m_bvpn[i] = 3'(i); m_bppn[i] = 3'(i); m_basid[i] = 8'd1; m_battr[i] = 4'h2;
      m_bw[i] = 1; m_bx[i] = 1;
    end
    m_rasid = 32'h0403_0201;
    m_vic = 0;
  endtask

  function automatic int ring_of(logic [7:0] a);
    if (a == 0) return -1;
    for (int r = 0; r < 4; r++) if (m_rasid[r*8 +: 8] == a) return r;
    return -1;
  endfunction

  task automatic expect_lk(input logic [31:0] va, input logic [1:0] ring, input logic w, input logic x,
                           output logic [3:0] flags, output logic [31:0] pa, output logic [3:0] at);
    int n = 0, er = 0;
    logic ew = 0, ex = 0;
    logic [31:0] epa = 0;
    logic [3:0] eat = 0;
    for (int i = 0; i < 8; i++)
      if (ring_of(m_pasid[i]) >= 0 && m_pvpn[i] == va[31:12]) begin
        n++; er = ring_of(m_pasid[i]); ew = m_pw[i]; ex = m_px[i];
        epa = {m_pppn[i], va[11:0]}; eat = m_pattr[i];
      end
    for (int i = 0; i < 8; i++)
      if (ring_of(m_basid[i]) >= 0 && m_bvpn[i] == va[31:29]) begin
        n++; er = ring_of(m_basid[i]); ew = m_bw[i]; ex = m_bx[i];
        epa = {m_bppn[i], va[28:0]}; eat = m_battr[i];
      end
    pa = 0; at = 0;
    if (n == 0) flags = 4'b0100;
    else if (n > 1) flags = 4'b0010;
    else if (int'(ring) > er || (w && !ew) || (x && !ex)) flags = 4'b0001;
    else begin flags = 4'b1000; pa = epa; at = eat; end
  endtask

  task automatic cmp_lk(input string req, input logic [31:0] va, input logic [1:0] ring,
                        input logic w, input logic x);
    logic [3:0] ef, af;
    logic [31:0] epa;
    logic [3:0] eat;
    expect_lk(va, ring, w, x, ef, epa, eat);
    af = {lk_hit_o, lk_miss_o, lk_multi_o, lk_perm_o};
    total++;
    if (af !== ef || lk_pa_o !== epa || lk_attr_o !== eat) begin
      bad++;
      $display("FAIL %s va=%h flags=%b pa=%h attr=%h expected flags=%b pa=%h attr=%h",
               req, va, af, lk_pa_o, lk_attr_o, ef, epa, eat);
    end
  endtask

  task automatic do_lk(input string req, input logic [31:0] va, input logic [1:0] ring,
                       input logic w, input logic x);
    @(negedge clk);
    lk_valid_i = 1; lk_va_i = va; lk_ring_i = ring; lk_wr_i = w; lk_ex_i = x;
    #1 cmp_lk(req, va, ring, w, x);
  endtask

  task automatic do_write(input logic boot, input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                          input logic [7:0] asid, input logic [3:0] attr, input logic w, input logic x);
    @(negedge clk);
    wr_en_i = 1; wr_boot_i = boot; wr_idx_i = 3'(idx); wr_vpn_i = vpn; wr_ppn_i = ppn;
    wr_asid_i = asid; wr_attr_i = attr; wr_w_i = w; wr_x_i = x;
    @(negedge clk);
    wr_en_i = 0;
    if (boot) begin
      m_bvpn[idx] = vpn[19:17]; m_bppn[idx] = ppn[19:17]; m_basid[idx] = asid;
      m_battr[idx] = attr; m_bw[idx] = w; m_bx[idx] = x;
    end else begin
      m_pvpn[idx] = vpn; m_pppn[idx] = ppn; m_pasid[idx] = asid;
      m_pattr[idx] = attr; m_pw[idx] = w; m_px[idx] = x;
    end
  endtask

  task automatic do_inv(input logic boot, input int idx);
    @(negedge clk);
    inv_en_i = 1; inv_boot_i = boot; inv_idx_i = 3'(idx);
    @(negedge clk);
    inv_en_i = 0;
    if (boot) m_basid[idx] = 0; else m_pasid[idx] = 0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [31:0] pte);
    int r;
    @(negedge clk);
    fill_en_i = 1; fill_vpn_i = vpn; fill_pte_i = pte;
    @(negedge clk);
    fill_en_i = 0;
    r = int'(pte[5:4]);
    m_pvpn[m_vic] = vpn; m_pppn[m_vic] = pte[31:12]; m_pasid[m_vic] = m_rasid[r*8 +: 8];
    m_pattr[m_vic] = pte[3:0]; m_pw[m_vic] = pte[6]; m_px[m_vic] = pte[7];
    m_vic = (m_vic + 1) % 8;
  endtask

  task automatic do_rasid(input logic [31:0] v);
    @(negedge clk);
    rasid_we_i = 1; rasid_i = v;
    @(negedge clk);
    rasid_we_i = 0;
    m_rasid = {v[31:8], 8'd1};
  endtask

  function automatic logic [7:0] pick_asid();
    case ($urandom % 7)
      0: return 8'd0; 1: return 8'd1; 2: return 8'd2; 3: return 8'd3;
      4: return 8'd4; 5: return 8'h33; default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [19:0] pick_vpn();
    return {3'($urandom % 8), 15'd0, 2'($urandom % 4)};
  endfunction

  initial begin
    #(CLK_P * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R10: idle lookup raises nothing
    @(negedge clk); lk_valid_i = 0; lk_va_i = 32'h3000_0000;
    #1 total++;
    if ({lk_hit_o, lk_miss_o, lk_multi_o, lk_perm_o} !== 4'b0) begin
      bad++; $display("FAIL R10 idle flags=%b expected 0000", {lk_hit_o, lk_miss_o, lk_multi_o, lk_perm_o});
    end

    // R1: reset identity map
    do_lk("R1", 32'h3000_1234, 2'd0, 0, 0);
    do_lk("R1", 32'hE000_0ABC, 2'd0, 1, 1);
    // R2: kernel only
    do_lk("R2", 32'h5000_0000, 2'd1, 0, 0);
    do_lk("R2", 32'hF000_0040, 2'd3, 0, 0);
    // R7: byte 0 write ignored
    do_rasid(32'h0403_02FF);
    do_lk("R7", 32'h7000_0010, 2'd0, 0, 0);
    // R4: page entry overlapping region 0
    do_write(0, 0, 20'h10000, 20'hABCDE, 8'd1, 4'h5, 1, 0);
    do_lk("R4", 32'h1000_0ABC, 2'd0, 0, 0);
    // R6: kill region 0, page entry alone remains
    do_inv(1, 0);
    do_lk("R3", 32'h1000_0ABC, 2'd0, 1, 0);
    do_lk("R6", 32'h0000_5000, 2'd0, 0, 0);
    // R10: write visible only after the edge
    @(negedge clk);
    wr_en_i = 1; wr_boot_i = 0; wr_idx_i = 3'd1; wr_vpn_i = 20'h00005; wr_ppn_i = 20'h12345;
    wr_asid_i = 8'd2; wr_attr_i = 4'h9; wr_w_i = 1; wr_x_i = 1;
    lk_valid_i = 1; lk_va_i = 32'h0000_5678; lk_ring_i = 2'd1; lk_wr_i = 0; lk_ex_i = 0;
    #1 cmp_lk("R10", 32'h0000_5678, 2'd1, 0, 0);
    m_pvpn[1] = 20'h00005; m_pppn[1] = 20'h12345; m_pasid[1] = 8'd2;
    m_pattr[1] = 4'h9; m_pw[1] = 1; m_px[1] = 1;
    @(posedge clk); #1 cmp_lk("R10", 32'h0000_5678, 2'd1, 0, 0);
    @(negedge clk); wr_en_i = 0;
    // R9: permissions and ring
    do_lk("R9", 32'h1000_0000, 2'd0, 0, 1);
    do_lk("R9", 32'h0000_5000, 2'd2, 0, 0);
    do_lk("R9", 32'h0000_5000, 2'd0, 1, 1);
    do_write(0, 2, 20'h00007, 20'h00070, 8'd3, 4'h1, 0, 1);
    do_lk("R9", 32'h0000_7000, 2'd2, 1, 0);
    // R11: space switch via register byte
    do_write(0, 3, 20'h00009, 20'h00090, 8'h33, 4'h4, 1, 1);
    do_lk("R11", 32'h0000_9004, 2'd3, 0, 0);
    do_rasid(32'h3303_0200);
    do_lk("R11", 32'h0000_9004, 2'd3, 0, 0);
    do_rasid(32'h0403_0201);
    // R6: invalidate page entry
    do_inv(0, 1);
    do_lk("R6", 32'h0000_5000, 2'd1, 0, 0);
    // R8: round robin fills, ninth evicts first
    for (int i = 0; i < 9; i++)
      do_fill(20'h00100 + 20'(i), {20'h40000 + 20'(i), 4'h0, 2'b11, 2'd1, 4'h6});
    do_lk("R8", 32'h0010_0000, 2'd1, 0, 0);
    do_lk("R8", 32'h0010_1000, 2'd1, 1, 1);
    do_lk("R8", 32'h0010_8FFF, 2'd1, 0, 0);
    do_lk("R8", 32'h0010_8FFF, 2'd2, 0, 0);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      case ($urandom % 8)
        0: do_write(0, int'($urandom % 8), pick_vpn(), 20'($urandom), pick_asid(),
                    4'($urandom), 1'($urandom), 1'($urandom));
        1: do_write(1, int'($urandom % 8), pick_vpn(), 20'($urandom), pick_asid(),
                    4'($urandom), 1'($urandom), 1'($urandom));
        2: do_inv(1'($urandom), int'($urandom % 8));
        3: do_fill(pick_vpn(), $urandom);
        4: do_rasid({pick_asid(), pick_asid(), pick_asid(), 8'($urandom)});
        default: do_lk("R3", {pick_vpn(), 12'($urandom)}, 2'($urandom), 1'($urandom), 1'($urandom));
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule